// File: doc/BRIEF.md
# Power-Rail Enable Sequencing Controller

This block is the digital control core of a three-rail power manager. It watches an active-low push-button master input, three active-high rail enable inputs, a digital die-temperature code and an input undervoltage flag. From them it drives three regulator enables, three output-discharge controls, an active-low interrupt and an active-low reset output. The reset output stays low for a timed interval after each power-up. It runs from a 1.6 MHz system oscillator.

The controller is active while the button is held or while any rail enable is high. Holding the button alone turns rail 1 on. This lets a processor boot and then assert its own rail 1 enable, so power stays on after the button is released. Shutdown is under software control: the processor drops its enables, and each rail turns off as soon as nothing requests it. An overtemperature lockout with hysteresis and an undervoltage flag each force every rail off. A software-written mask bit silences the interrupt.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: When the synchronized button input is high and all three rail enables are low, the controller is inactive and all three rail outputs are low.
- R2: Rail 1 (`rail_on_o[0]`) is on while `rail_req_i[0]` is high or while the button input `btn_n_i` is low, provided no fault is present.
- R3: Rail 2 (`rail_on_o[1]`) follows only `rail_req_i[1]`, and rail 3 (`rail_on_o[2]`) follows only `rail_req_i[2]`. The button has no effect on either of them.
- R4: Each discharge output `dischg_o[i]` is the inverse of `rail_on_o[i]`, so every rail that is off is pulled down.
- R5: A temperature code above `TRIP_C` (default 160, units of °C) sets the thermal lockout one clock after the synchronized code, and every rail output goes low.
- R6: Once set, the lockout stays set while the code is above `CLEAR_C` (default 140). It clears when the code is at or below `CLEAR_C`. A code of exactly `TRIP_C` does not trip the lockout.
- R7: `rst_n_o` is low while the controller is inactive. After the controller becomes active it stays low for `RST_CYCLES` = `CLK_HZ`/1000*`RST_MS`/`SCALE` clocks (480,000 by default, which is 300 ms), then goes high. Its first high sample comes `RST_CYCLES`+2 rising edges after the activating input change. Each return from inactive restarts the count.
- R8: A high undervoltage flag `uv_i` forces all rail outputs low.
- R9: `irq_n_o` is low while the button is held low or a fault (thermal lockout or undervoltage) is present, unless the mask is set.
- R10: The mask bit is written with `mask_we_i`/`mask_d_i` and reads 0 after reset. When set to 1 it holds `irq_n_o` high and leaves the rail outputs unchanged.
- R11: Every asynchronous input passes through two flops. A change applied between rising edges reaches the rail outputs after the second rising edge, not after the first.
- R12: In reset, the rail outputs are 0, the discharge outputs are all 1, `irq_n_o` is 1 and `rst_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.6 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset for the logic |
| btn_n_i | input | 1 | Active-low push-button master input (asynchronous) |
| rail_req_i | input | 3 | Active-high enable requests for rails 1..3 (bit 0 = rail 1), asynchronous |
| temp_code_i | input | TEMP_W (8) | Die temperature in °C, asynchronous, slowly changing |
| uv_i | input | 1 | Input undervoltage flag, asynchronous, high = fault |
| mask_we_i | input | 1 | Write strobe for the interrupt mask bit |
| mask_d_i | input | 1 | Value written to the mask bit (1 = masked) |
| rail_on_o | output | 3 | Regulator enables, bit 0 = rail 1 |
| dischg_o | output | 3 | Output-discharge controls, high while the matching rail is off |
| irq_n_o | output | 1 | Active-low interrupt |
| rst_n_o | output | 1 | Active-low system reset output |

## Verification
A lockout flop stuck in the wrong state shows up at once on all three rail outputs. The worst case is a code in the 141–160 band, where only the stored state decides the outcome, so the bench spends time on that band. A reset counter that is off by even one cycle moves the first high sample of `rst_n_o` by a clock. That edge is checked on both sides, both after power-up and after a restart. Errors in the synchronizer depth or the mask bit show within two or three cycles, either on the rail outputs or on `irq_n_o`.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // Reset hold length in clocks, scaled down for simulation.
  function automatic int unsigned rst_hold_cycles(input int unsigned clk_hz,
                                                  input int unsigned hold_ms,
                                                  input int unsigned scale);
    return (clk_hz / 1000) * hold_ms / scale;
  endfunction

  // Thermal lockout next state from the current state and the code.
  function automatic logic lockout_next(input logic hot,
                                        input int unsigned code,
                                        input int unsigned trip_c,
                                        input int unsigned clear_c);
    if (code > trip_c)        return 1'b1;
    else if (code <= clear_c) return 1'b0;
    else                      return hot;
  endfunction

endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= INIT;
      q      <= INIT;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

  // R11: the output is the input from two edges earlier.
  assert_two_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> q == $past(meta_q));
endmodule

// File: rtl/pwr_thermal_lock.sv
module pwr_thermal_lock
  import pwr_seq_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 160,
  parameter int CLEAR_C = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] code,
  output logic              hot
);
  localparam int unsigned TRIP_U  = TRIP_C;
  localparam int unsigned CLEAR_U = CLEAR_C;

  logic code_over, code_clear;
  assign code_over  = int'(code) > TRIP_C;
  assign code_clear = int'(code) <= CLEAR_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= lockout_next(hot, int'(code), TRIP_U, CLEAR_U);
  end

  assert_trip_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_over |=> hot);
  assert_band_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && !code_clear) |=> hot);
  assert_no_trip_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && !code_over) |=> !hot);
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int RST_CYCLES = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic rst_n_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          cnt_last;
  assign cnt_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_n_o <= 1'b0;
    end else if (!active) begin
      cnt_q   <= '0;
      rst_n_o <= 1'b0;
    end else if (!rst_n_o) begin
      cnt_q   <= cnt_q + 1'b1;
      rst_n_o <= cnt_last;
    end
  end

  assert_low_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rst_n_o);
  assert_release_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> $past(active));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RST_CYCLES));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NRAIL   = 3,
  parameter int TEMP_W  = 8,
  parameter int TRIP_C  = 160,
  parameter int CLEAR_C = 140,
  parameter int CLK_HZ  = 1600000,
  parameter int RST_MS  = 300,
  parameter int SCALE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_n_i,
  input  logic [2:0]        rail_req_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              uv_i,
  input  logic              mask_we_i,
  input  logic              mask_d_i,
  output logic [2:0]        rail_on_o,
  output logic [2:0]        dischg_o,
  output logic              irq_n_o,
  output logic              rst_n_o
);
  localparam int RST_CYCLES = int'(rst_hold_cycles(CLK_HZ, RST_MS, SCALE));
  localparam int SW = 1 + NRAIL + 1;

  logic [SW-1:0]     s_bits;
  logic [TEMP_W-1:0] s_temp;
  logic              s_btn_n, s_uv;
  logic [2:0]        s_req;

  pwr_sync2 #(.W(SW), .INIT({1'b1, 3'b000, 1'b0})) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({btn_n_i, rail_req_i, uv_i}), .q(s_bits));
  pwr_sync2 #(.W(TEMP_W), .INIT('0)) u_sync_temp (
    .clk(clk), .rst_n(rst_n), .d(temp_code_i), .q(s_temp));

  assign s_btn_n = s_bits[SW-1];
  assign s_req   = s_bits[NRAIL:1];
  assign s_uv    = s_bits[0];

  // Named internal events.
  logic btn_held, active, hot, fault, mask_q;
  logic [2:0] rail_want;
  assign btn_held = !s_btn_n;
  assign active   = btn_held || (|s_req);

  pwr_thermal_lock #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .CLEAR_C(CLEAR_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .code(s_temp), .hot(hot));

  assign fault = hot || s_uv;

  // Rail 1 also answers the button; the others only their own request.
  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    if (i == 0) begin : g_btn
      assign rail_want[i] = s_req[i] || btn_held;
    end else begin : g_plain
      assign rail_want[i] = s_req[i];
    end
    assign rail_on_o[i] = rail_want[i] && !fault;
    assign dischg_o[i]  = !rail_on_o[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= 1'b0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign irq_n_o = !((btn_held || fault) && !mask_q);

  pwr_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .active(active), .rst_n_o(rst_n_o));

  assert_idle_rails_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> rail_on_o == 3'b000);
  assert_rail2_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rail_on_o[1] |-> s_req[1]);
  assert_rail3_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rail_on_o[2] |-> s_req[2]);
  assert_hot_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> rail_on_o == 3'b000);
  assert_uv_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_uv |-> rail_on_o == 3'b000);
  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> irq_n_o);
  assert_dischg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_on_o & dischg_o) == 3'b000);
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SCALE_SIM  = 12000;
  localparam int NRST       = 1600000 / 1000 * 300 / SCALE_SIM;  // 40

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n_i = 1'b1;
  logic [2:0] rail_req_i = 3'b000;
  logic [7:0] temp_code_i = 8'd25;
  logic uv_i = 1'b0;
  logic mask_we_i = 1'b0;
  logic mask_d_i = 1'b0;
  logic [2:0] rail_on_o, dischg_o;
  logic irq_n_o, rst_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.SCALE(SCALE_SIM)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_n_i(btn_n_i), .rail_req_i(rail_req_i),
    .temp_code_i(temp_code_i), .uv_i(uv_i), .mask_we_i(mask_we_i),
    .mask_d_i(mask_d_i), .rail_on_o(rail_on_o), .dischg_o(dischg_o),
    .irq_n_o(irq_n_o), .rst_n_o(rst_n_o));

  // {btn_n, req[2:0], uv, exp_rail[2:0], exp_irq_n}
  localparam logic [8:0] VEC [9] = '{
    {1'b1, 3'b000, 1'b0, 3'b000, 1'b1},
    {1'b0, 3'b000, 1'b0, 3'b001, 1'b0},
    {1'b0, 3'b001, 1'b0, 3'b001, 1'b0},
    {1'b1, 3'b001, 1'b0, 3'b001, 1'b1},
    {1'b1, 3'b110, 1'b0, 3'b110, 1'b1},
    {1'b1, 3'b111, 1'b0, 3'b111, 1'b1},
    {1'b1, 3'b111, 1'b1, 3'b000, 1'b0},
    {1'b0, 3'b100, 1'b0, 3'b101, 1'b0},
    {1'b1, 3'b010, 1'b0, 3'b010, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R12 reset state
    chk("R12 rails", {29'd0, rail_on_o}, 32'h0);
    chk("R12 dischg", {29'd0, dischg_o}, 32'h7);
    chk("R12 irq_n", {31'd0, irq_n_o}, 32'h1);
    chk("R12 rst_n_o", {31'd0, rst_n_o}, 32'h0);
    step(3);

    // R11 synchronizer depth
    rail_req_i = 3'b010;
    step(1);
    chk("R11 after one edge", {29'd0, rail_on_o}, 32'h0);
    step(1);
    chk("R11 after two edges", {29'd0, rail_on_o}, 32'h2);
    rail_req_i = 3'b000;
    step(3);
    chk("R1 idle rails off", {29'd0, rail_on_o}, 32'h0);

    // Table walk: R1 R2 R3 R4 R8 R9
    for (int v = 0; v < 9; v++) begin
      btn_n_i    = VEC[v][8];
      rail_req_i = VEC[v][7:5];
      uv_i       = VEC[v][4];
      step(3);
      chk("R1/R2/R3/R8 rails", {29'd0, rail_on_o}, {29'd0, VEC[v][3:1]});
      chk("R4 dischg", {29'd0, dischg_o}, {29'd0, ~VEC[v][3:1]});
      chk("R9 irq_n", {31'd0, irq_n_o}, {31'd0, VEC[v][0]});
    end

    // R7 reset hold timing
    btn_n_i = 1'b1; rail_req_i = 3'b000; uv_i = 1'b0;
    step(4);
    chk("R7 low when idle", {31'd0, rst_n_o}, 32'h0);
    rail_req_i = 3'b001;
    step(NRST + 1);
    chk("R7 still low at N+1", {31'd0, rst_n_o}, 32'h0);
    step(1);
    chk("R7 released at N+2", {31'd0, rst_n_o}, 32'h1);
    rail_req_i = 3'b000;
    step(3);
    chk("R7 low after going idle", {31'd0, rst_n_o}, 32'h0);
    btn_n_i = 1'b0;
    step(NRST + 1);
    chk("R7 restart still low", {31'd0, rst_n_o}, 32'h0);
    step(1);
    chk("R7 restart released", {31'd0, rst_n_o}, 32'h1);
    btn_n_i = 1'b1;

    // R5/R6 thermal hysteresis
    rail_req_i = 3'b111;
    temp_code_i = 8'd160;
    step(3);
    chk("R6 at trip level stays on", {29'd0, rail_on_o}, 32'h7);
    temp_code_i = 8'd161;
    step(3);
    chk("R5 over trip all off", {29'd0, rail_on_o}, 32'h0);
    chk("R9 fault irq", {31'd0, irq_n_o}, 32'h0);
    temp_code_i = 8'd150;
    step(3);
    chk("R6 150 still locked", {29'd0, rail_on_o}, 32'h0);
    temp_code_i = 8'd141;
    step(3);
    chk("R6 141 still locked", {29'd0, rail_on_o}, 32'h0);
    temp_code_i = 8'd140;
    step(3);
    chk("R6 140 clears", {29'd0, rail_on_o}, 32'h7);
    chk("R9 irq clear", {31'd0, irq_n_o}, 32'h1);
    temp_code_i = 8'd150;
    step(3);
    chk("R6 150 from cool stays on", {29'd0, rail_on_o}, 32'h7);
    temp_code_i = 8'd25;
    rail_req_i = 3'b000;
    step(3);

    // R10 mask
    mask_we_i = 1'b1; mask_d_i = 1'b1;
    step(1);
    mask_we_i = 1'b0;
    btn_n_i = 1'b0;
    step(3);
    chk("R10 masked irq high", {31'd0, irq_n_o}, 32'h1);
    chk("R10 rails unaffected", {29'd0, rail_on_o}, 32'h1);
    mask_we_i = 1'b1; mask_d_i = 1'b0;
    step(1);
    mask_we_i = 1'b0;
    chk("R10 unmasked irq low", {31'd0, irq_n_o}, 32'h0);
    btn_n_i = 1'b1;
    step(3);

    summary();
  end
endmodule